// File: doc/BRIEF.md
# ADC Control Register Sequencer

This block is the digital front end of a general-purpose analog-to-digital converter. It holds five 16-bit registers on a simple bus with address, write data, write strobe and read data. It turns their contents into the control lines of the analog converter core: enable, start, clock select, attenuator, load-current controls, delay enable and the offset trim words. The converter returns a one-cycle done pulse. Software writes a start bit to launch a conversion. When the done pulse arrives, that bit drops back to 0 by itself and a sticky interrupt flag is raised.

The interrupt flag is cleared only by writing any value to a dedicated clear register. A further conversion is accepted only after the delay-enable bit has changed value since the last accepted start. The two offset trims are routed to the core according to the single-ended and sign mode inputs.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the control and control-2 registers read 0x0000, both offset registers read 0x0200, the interrupt is low and every core control output is low.
- R2: The control register at offset 0x0 reads {11'b0, irq, clock select, 1'b0, start, enable}. Bit 3 drives the clock-select output. Bit 2 always reads 0.
- R3: The enable bit drives the core enable output, where 0 holds the core in reset. Writing enable to 0 also clears start in the same cycle.
- R4: Writing 1 to start (bit 1) sets start only if the written enable bit is 1, no conversion is in progress and the delay gate is armed. Otherwise start stays as it was, so a refused start on an idle block reads 0.
- R5: A done pulse while start is 1 clears start and sets the interrupt flag, both visible one cycle later.
- R6: The interrupt flag stays set until a write of any value to offset 0x8. Reads of offset 0x8, and of unmapped offsets, return 0.
- R7: If a done pulse (with start set) and a write to offset 0x8 occur in the same cycle, the interrupt flag ends up set.
- R8: Control-2 at offset 0x2 holds delay enable (bit 0), 3x attenuator (bit 1), dynamic load (bit 2) and constant load (bit 3), each driving its own output. Bits 15:4 read 0.
- R9: The delay gate is armed at reset. It is disarmed by each accepted start and re-armed by any write that changes the delay-enable bit.
- R10: Offset registers at 0x4 (positive) and 0x6 (negative) keep only bits 9:0. Bits 15:10 read 0.
- R11: The positive trim output carries the positive offset when single-ended mode is 0, or when sign is 0, and is 0 otherwise. The negative trim output carries the negative offset when single-ended mode is 0, or when sign is 1, and is 0 otherwise.
- R12: A done pulse while start is 0 changes neither the start bit nor the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| se_mode | input | 1 | 1 = single-ended, 0 = differential |
| sign_sel | input | 1 | Selects the array in single-ended mode |
| conv_done | input | 1 | Conversion-finished pulse from the core |
| core_en | output | 1 | Core enable, 0 holds the core in reset |
| core_start | output | 1 | Conversion in progress / start request |
| core_clk_sel | output | 1 | 0 = internal fast clock, 1 = digital clock |
| core_attn3x | output | 1 | 3x input attenuator select |
| core_dyn_load | output | 1 | Dynamic load-current enable |
| core_const_load | output | 1 | Constant load-current enable |
| core_delay_en | output | 1 | Delay-enable line |
| trim_pos | output | 10 | Positive-array offset trim |
| trim_neg | output | 10 | Negative-array offset trim |
| irq | output | 1 | Level interrupt, conversion ready |

## Verification
A wrong start or gate state shows on core_start one cycle after the write or done pulse that should have changed it. The bench compares that output on every clock. A corrupted interrupt flag shows on irq and on bit 4 of the control readback in the cycle after the event. A mis-routed trim appears at once on the trim outputs, because they are combinational from the mode inputs. The cycle-by-cycle model catches a lost delay-gate re-arm only when the next start write is refused or accepted, so the bench issues starts both with and without a toggle in between.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CTRL2 = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_OFFP  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_OFFN  = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 4'h8;

  typedef struct packed {
    logic const_load;
    logic dyn_load;
    logic attn3x;
    logic delay_en;
  } analog_cfg_t;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int TRIM_W = 10,
  parameter logic [TRIM_W-1:0] TRIM_RST = 10'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_ctrl,
  input  logic              wr_ctrl2,
  input  logic              wr_offp,
  input  logic              wr_offn,
  output logic              en,
  output logic              clk_sel,
  output analog_cfg_t       cfg,
  output logic [TRIM_W-1:0] offp,
  output logic [TRIM_W-1:0] offn,
  output logic              dly_changed
);
  logic              en_d, clk_sel_d;
  analog_cfg_t       cfg_d;
  logic [TRIM_W-1:0] offp_d, offn_d;

  always_comb begin
    en_d      = en;
    clk_sel_d = clk_sel;
    cfg_d     = cfg;
    offp_d    = offp;
    offn_d    = offn;
    if (wr_ctrl) begin
      en_d      = wdata[0];
      clk_sel_d = wdata[3];
    end
    if (wr_ctrl2) cfg_d = analog_cfg_t'(wdata[3:0]);
    if (wr_offp)  offp_d = wdata[TRIM_W-1:0];
    if (wr_offn)  offn_d = wdata[TRIM_W-1:0];
  end

  assign dly_changed = wr_ctrl2 && (wdata[0] != cfg.delay_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      clk_sel <= 1'b0;
      cfg     <= '0;
      offp    <= TRIM_RST;
      offn    <= TRIM_RST;
    end else begin
      en      <= en_d;
      clk_sel <= clk_sel_d;
      cfg     <= cfg_d;
      offp    <= offp_d;
      offn    <= offn_d;
    end
  end

  AST_OFFP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_offp |=> $stable(offp)); // R10
endmodule

// File: rtl/adc_seq_conv.sv
module adc_seq_conv (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic wr_ctrl,
  input  logic wr_en_bit,
  input  logic wr_start_bit,
  input  logic wr_clr,
  input  logic done,
  input  logic dly_changed,
  output logic start,
  output logic irq,
  output logic armed
);
  logic start_d, irq_d, armed_d, en_new, finish, accept;

  always_comb begin
    en_new  = wr_ctrl ? wr_en_bit : en;
    finish  = start && done;
    accept  = wr_ctrl && wr_start_bit && en_new && !start && armed;
    start_d = start;
    armed_d = armed;
    if (!en_new)     start_d = 1'b0;
    else if (finish) start_d = 1'b0;
    else if (accept) start_d = 1'b1;
    if (accept && en_new) armed_d = 1'b0;
    else if (dly_changed) armed_d = 1'b1;
    if (finish)      irq_d = 1'b1;
    else if (wr_clr) irq_d = 1'b0;
    else             irq_d = irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start <= 1'b0;
      irq   <= 1'b0;
      armed <= 1'b1;
    end else begin
      start <= start_d;
      irq   <= irq_d;
      armed <= armed_d;
    end
  end

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> en); // R3
  AST_DONE_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && done) |=> (irq && !start)); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_clr) |=> irq); // R6
  AST_DONE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && done && wr_clr) |=> irq); // R7
  AST_START_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start) |-> $past(armed)); // R9
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && done && !wr_clr) |=> ($stable(irq))); // R12
endmodule

// File: rtl/adc_seq_trim.sv
module adc_seq_trim #(
  parameter int TRIM_W = 10
) (
  input  logic              se_mode,
  input  logic              sign_sel,
  input  logic [TRIM_W-1:0] offp,
  input  logic [TRIM_W-1:0] offn,
  output logic [TRIM_W-1:0] trim_pos,
  output logic [TRIM_W-1:0] trim_neg
);
  logic use_p, use_n;

  always_comb begin
    use_p    = !se_mode || !sign_sel;
    use_n    = !se_mode ||  sign_sel;
    trim_pos = use_p ? offp : '0;
    trim_neg = use_n ? offn : '0;
  end

  always_comb begin
    assert (se_mode ? (trim_pos == '0 || trim_neg == '0 || offp == '0 || offn == '0) : 1'b1)
      else $error("AST_SE_ONE_ARRAY"); // R11
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int TRIM_W = 10,
  parameter logic [TRIM_W-1:0] TRIM_RST = 10'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              se_mode,
  input  logic              sign_sel,
  input  logic              conv_done,
  output logic              core_en,
  output logic              core_start,
  output logic              core_clk_sel,
  output logic              core_attn3x,
  output logic              core_dyn_load,
  output logic              core_const_load,
  output logic              core_delay_en,
  output logic [TRIM_W-1:0] trim_pos,
  output logic [TRIM_W-1:0] trim_neg,
  output logic              irq
);
  localparam int PAD_W = DATA_W - TRIM_W;

  logic wr_ctrl, wr_ctrl2, wr_offp, wr_offn, wr_clr;
  logic en, clk_sel, dly_changed, start, irq_q, armed;
  analog_cfg_t cfg;
  logic [TRIM_W-1:0] offp, offn;

  assign wr_ctrl  = bus_we && (bus_addr == OFS_CTRL);
  assign wr_ctrl2 = bus_we && (bus_addr == OFS_CTRL2);
  assign wr_offp  = bus_we && (bus_addr == OFS_OFFP);
  assign wr_offn  = bus_we && (bus_addr == OFS_OFFN);
  assign wr_clr   = bus_we && (bus_addr == OFS_CLR);

  adc_seq_regs #(.TRIM_W(TRIM_W), .TRIM_RST(TRIM_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wdata(bus_wdata),
    .wr_ctrl(wr_ctrl), .wr_ctrl2(wr_ctrl2), .wr_offp(wr_offp), .wr_offn(wr_offn),
    .en(en), .clk_sel(clk_sel), .cfg(cfg), .offp(offp), .offn(offn),
    .dly_changed(dly_changed)
  );

  adc_seq_conv u_conv (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_ctrl(wr_ctrl),
    .wr_en_bit(bus_wdata[0]), .wr_start_bit(bus_wdata[1]),
    .wr_clr(wr_clr), .done(conv_done), .dly_changed(dly_changed),
    .start(start), .irq(irq_q), .armed(armed)
  );

  adc_seq_trim #(.TRIM_W(TRIM_W)) u_trim (
    .se_mode(se_mode), .sign_sel(sign_sel), .offp(offp), .offn(offn),
    .trim_pos(trim_pos), .trim_neg(trim_neg)
  );

  always_comb begin
    case (bus_addr)
      OFS_CTRL:  bus_rdata = {11'b0, irq_q, clk_sel, 1'b0, start, en};
      OFS_CTRL2: bus_rdata = {12'b0, cfg};
      OFS_OFFP:  bus_rdata = {{PAD_W{1'b0}}, offp};
      OFS_OFFN:  bus_rdata = {{PAD_W{1'b0}}, offn};
      default:   bus_rdata = '0;
    endcase
  end

  assign core_en         = en;
  assign core_start      = start;
  assign core_clk_sel    = clk_sel;
  assign core_attn3x     = cfg.attn3x;
  assign core_dyn_load   = cfg.dyn_load;
  assign core_const_load = cfg.const_load;
  assign core_delay_en   = cfg.delay_en;
  assign irq             = irq_q;

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_CLR) |-> (bus_rdata == '0)); // R6
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[0]) |=> !core_start); // R3
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  localparam int LAT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic bus_we = 1'b0;
  logic se_mode = 1'b0, sign_sel = 1'b0, conv_done = 1'b0;
  logic [15:0] bus_rdata;
  logic core_en, core_start, core_clk_sel, core_attn3x, core_dyn_load;
  logic core_const_load, core_delay_en, irq;
  logic [9:0] trim_pos, trim_neg;

  always #2 clk = ~clk;

  adc_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .se_mode(se_mode), .sign_sel(sign_sel),
    .conv_done(conv_done), .core_en(core_en), .core_start(core_start),
    .core_clk_sel(core_clk_sel), .core_attn3x(core_attn3x),
    .core_dyn_load(core_dyn_load), .core_const_load(core_const_load),
    .core_delay_en(core_delay_en), .trim_pos(trim_pos), .trim_neg(trim_neg), .irq(irq)
  );

  int checks = 0, fails = 0, cnt = 0;
  bit auto_conv = 1'b1;

  // behavioural reference state
  bit m_en, m_clk, m_start, m_irq, m_armed;
  bit [3:0] m_cfg;
  int m_offp, m_offn;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_clk = 0; m_start = 0; m_irq = 0; m_armed = 1;
      m_cfg = 0; m_offp = 'h200; m_offn = 'h200;
    end else begin
      bit fin, new_en;
      fin = conv_done && m_start;
      new_en = m_en;
      if (bus_we && bus_addr == 4'h0) begin
        new_en = bus_wdata[0];
        m_clk = bus_wdata[3];
        if (!new_en) m_start = 0;
        else if (fin) m_start = 0;
        else if (bus_wdata[1] && !m_start && m_armed) begin m_start = 1; m_armed = 0; end
      end else if (fin) m_start = 0;
      m_en = new_en;
      if (bus_we && bus_addr == 4'h2) begin
        if (bus_wdata[0] != m_cfg[0]) m_armed = 1;
        m_cfg = bus_wdata[3:0];
      end
      if (bus_we && bus_addr == 4'h4) m_offp = bus_wdata & 'h3FF;
      if (bus_we && bus_addr == 4'h6) m_offn = bus_wdata & 'h3FF;
      if (fin) m_irq = 1;
      else if (bus_we && bus_addr == 4'h8) m_irq = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_rd();
    case (bus_addr)
      4'h0: return (int'(m_irq) << 4) | (int'(m_clk) << 3) | (int'(m_start) << 1) | int'(m_en);
      4'h2: return int'(m_cfg);
      4'h4: return m_offp;
      4'h6: return m_offn;
      default: return 0;
    endcase
  endfunction

  task automatic tick();
    int ep, en_;
    @(negedge clk);
    ep  = (!se_mode || !sign_sel) ? m_offp : 0;
    en_ = (!se_mode ||  sign_sel) ? m_offn : 0;
    chk(bus_rdata == exp_rd(), "R2/R6/R8/R10 readback", bus_rdata, exp_rd());
    chk(core_en == m_en, "R3 core_en", core_en, m_en);
    chk(core_start == m_start, "R4/R5/R9 core_start", core_start, m_start);
    chk(irq == m_irq, "R5/R6/R7/R12 irq", irq, m_irq);
    chk(core_clk_sel == m_clk, "R2 clk_sel", core_clk_sel, m_clk);
    chk({core_const_load, core_dyn_load, core_attn3x, core_delay_en} == m_cfg,
        "R8 analog controls", {core_const_load, core_dyn_load, core_attn3x, core_delay_en}, m_cfg);
    chk(trim_pos == ep, "R11 trim_pos", trim_pos, ep);
    chk(trim_neg == en_, "R11 trim_neg", trim_neg, en_);
    if (auto_conv) begin
      conv_done = 1'b0;
      if (core_start) begin
        cnt++;
        if (cnt >= LAT) begin conv_done = 1'b1; cnt = 0; end
      end else cnt = 0;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    bus_addr = a; tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd(4'h0); rd(4'h2); rd(4'h4); rd(4'h6); rd(4'h8); rd(4'hA);
    // R2 clock select, reserved bit reads 0
    wr(4'h0, 16'h000C); rd(4'h0);
    // R4 start while disabled is refused
    wr(4'h0, 16'h0002); rd(4'h0);
    // R3 enable, then start accepted (gate armed from reset, R9)
    wr(4'h0, 16'h0001); wr(4'h0, 16'h0003); rd(4'h0);
    // R4 second start during a running conversion
    wr(4'h0, 16'h0003);
    idle(LAT + 2);                               // R5 completes
    rd(4'h8); idle(3);                           // R6 sticky, reads 0
    wr(4'h8, 16'h1234); rd(4'h0);                // R6 clear
    // R9 start without toggling delay enable is refused
    wr(4'h0, 16'h0003); rd(4'h0); idle(2);
    wr(4'h2, 16'h0001); wr(4'h0, 16'h0003); idle(2);
    // R3 disable during conversion drops start
    wr(4'h0, 16'h0000); rd(4'h0); idle(LAT + 1);
    // R9 toggle twice still re-arms
    wr(4'h2, 16'h0000); wr(4'h2, 16'h0001); wr(4'h0, 16'h0003); rd(4'h0);
    // R7 done and clear in the same cycle
    auto_conv = 1'b0; conv_done = 1'b0; cnt = 0;
    idle(2);
    conv_done = 1'b1; wr(4'h8, 16'h0000); conv_done = 1'b0;
    rd(4'h0); idle(2);
    // R12 done while idle
    wr(4'h8, 16'h0000);
    conv_done = 1'b1; tick(); conv_done = 1'b0; rd(4'h0);
    auto_conv = 1'b1;
    // R8 control-2 reserved bits, outputs
    wr(4'h2, 16'hFFFF); rd(4'h2); wr(4'h2, 16'h0006); rd(4'h2);
    // R10 offsets
    wr(4'h4, 16'hFFFF); rd(4'h4); wr(4'h6, 16'h0155); rd(4'h6);
    wr(4'h4, 16'h02AA); rd(4'h4);
    // R11 mode combinations
    se_mode = 0; sign_sel = 0; tick(); sign_sel = 1; tick();
    se_mode = 1; sign_sel = 0; tick(); sign_sel = 1; tick();
    se_mode = 0; tick();
    finish_run();
  end
endmodule